// File: doc/BRIEF.md
# Latched Tri-Port Bus Exchanger

This block passes 16-bit words between a processor-side port X and two memory-side ports: Y, which serves the even bank, and Z, which serves the odd bank. Each of the four transfer directions has its own latch. The two write latches carry X into Y and X into Z. The two read latches carry Y into X and Z into X. Each latch is transparent while its enable is high. It keeps the last word it let through once its enable goes low.

A path select picks the even pair (X with Y) or the odd pair (X with Z). A direction input decides whether X receives or drives. Two active-low byte enables decide which bytes actually drive. Each bidirectional port is split into an input bus, an output bus and two byte-wide drive-enable bits. A pad ring outside the block builds the tristate buffers from these.

The latches are built from a clocked hold register and a bypass multiplexer. The output follows the input combinationally while the enable is high. The output shows the value captured at the last rising clock edge where the enable was high once the enable is low.

Top module: `tri_port_exchanger`

## Requirements
- R1: While a latch enable is high, that latch's output equals its input in the same cycle, with no clock edge in between.
- R2: After the last rising clock edge with a latch enable high, the latch output holds the word captured at that edge for as long as the enable stays low, whatever its input does.
- R3: `x_out` shows the Y-read latch when `path_even` is 1 and the Z-read latch when `path_even` is 0.
- R4: `y_out` always shows the X-to-Y latch, and `z_out` always shows the X-to-Z latch, whatever the path and direction.
- R5: In every `_oe` bus, bit 1 gates bits 15:8 and bit 0 gates bits 7:0. `x_oe[1]` = !`dir_tx` && !`oe_hi_n`, and `x_oe[0]` = !`dir_tx` && !`oe_lo_n`.
- R6: `y_oe` bits are set only when `dir_tx`=1 and `path_even`=1, and `z_oe` bits are set only when `dir_tx`=1 and `path_even`=0. In both cases each bit also needs its byte enable low.
- R7: When `oe_hi_n` and `oe_lo_n` are both 1, all six drive-enable bits are 0.
- R8: Y and Z are never enabled in the same cycle, and X is never enabled in a cycle in which Y or Z is enabled.
- R9: Changes on `path_even`, `dir_tx`, `oe_hi_n` or `oe_lo_n` leave every latch's held word unchanged.
- R10: An active-low asynchronous reset clears all four held words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the hold registers |
| rst_n | input | 1 | Asynchronous active-low reset of the held words |
| x_in | input | 16 | Data arriving at port X |
| x_out | output | 16 | Data to drive onto port X |
| x_oe | output | 2 | Byte drive enables for X, bit 1 upper |
| y_in | input | 16 | Data arriving at port Y |
| y_out | output | 16 | Data to drive onto port Y |
| y_oe | output | 2 | Byte drive enables for Y, bit 1 upper |
| z_in | input | 16 | Data arriving at port Z |
| z_out | output | 16 | Data to drive onto port Z |
| z_oe | output | 2 | Byte drive enables for Z, bit 1 upper |
| le_xy | input | 1 | Enable of the X-to-Y write latch |
| le_xz | input | 1 | Enable of the X-to-Z write latch |
| le_yx | input | 1 | Enable of the Y-to-X read latch |
| le_zx | input | 1 | Enable of the Z-to-X read latch |
| path_even | input | 1 | 1 selects X and Y, 0 selects X and Z |
| dir_tx | input | 1 | 1 makes X receive, 0 makes X drive |
| oe_hi_n | input | 1 | Active-low enable of the upper byte |
| oe_lo_n | input | 1 | Active-low enable of the lower byte |

## Verification
The following are checked on every cycle:
- Write-latch transparency and hold.
- Read-source steering while the even read latch is open.
- Which direction and path combinations may set Y's enables.
- The all-off state.
- The mutual exclusion of the three ports' drivers.

Some properties need a scenario to show them:
- That a held word survives steering changes.
- That the Z-side latches and the read latches hold correctly.
- That a single byte drives while its partner stays off.

The bench covers these with directed sequences and a random sweep compared against its own model of the four latches.

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] x_in,
  output logic [DATA_W-1:0] x_out,
  output logic [1:0]        x_oe,
  input  logic [DATA_W-1:0] y_in,
  output logic [DATA_W-1:0] y_out,
  output logic [1:0]        y_oe,
  input  logic [DATA_W-1:0] z_in,
  output logic [DATA_W-1:0] z_out,
  output logic [1:0]        z_oe,
  input  logic              le_xy,
  input  logic              le_xz,
  input  logic              le_yx,
  input  logic              le_zx,
  input  logic              path_even,
  input  logic              dir_tx,
  input  logic              oe_hi_n,
  input  logic              oe_lo_n
);
  localparam int NLAT = 4;

  logic [NLAT-1:0][DATA_W-1:0] lat_d, lat_q, held;
  logic [NLAT-1:0]             lat_en;
  logic [1:0]                  byte_on;

  // slot 0: X->Y, 1: X->Z, 2: Y->X, 3: Z->X
  assign lat_d  = {z_in, y_in, x_in, x_in};
  assign lat_en = {le_zx, le_yx, le_xz, le_xy};

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held[i] <= '0;
      else if (lat_en[i]) held[i] <= lat_d[i];
    end
    assign lat_q[i] = lat_en[i] ? lat_d[i] : held[i];
  end

  assign y_out = lat_q[0];
  assign z_out = lat_q[1];
  assign x_out = path_even ? lat_q[2] : lat_q[3];

  assign byte_on = {~oe_hi_n, ~oe_lo_n};
  assign x_oe    = {2{~dir_tx}} & byte_on;
  assign y_oe    = {2{dir_tx & path_even}} & byte_on;
  assign z_oe    = {2{dir_tx & ~path_even}} & byte_on;
endmodule

module exchanger_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] x_in,
  input logic [DATA_W-1:0] y_in,
  input logic [DATA_W-1:0] x_out,
  input logic [DATA_W-1:0] y_out,
  input logic              le_xy,
  input logic              le_yx,
  input logic              path_even,
  input logic              dir_tx,
  input logic              oe_hi_n,
  input logic              oe_lo_n,
  input logic [1:0]        x_oe,
  input logic [1:0]        y_oe,
  input logic [1:0]        z_oe
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R1
  xy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_xy |-> (y_out == x_in));

  // R2
  xy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !le_xy) |=> (le_xy || $stable(y_out)));

  // R3
  read_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (path_even && le_yx) |-> (x_out == y_in));

  // R6
  y_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|y_oe) |-> (dir_tx && path_even));

  // R7
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_hi_n && oe_lo_n) |-> (x_oe == 2'b00 && y_oe == 2'b00 && z_oe == 2'b00));

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|y_oe) && (|z_oe)) && !((|x_oe) && ((|y_oe) || (|z_oe))));
endmodule

bind tri_port_exchanger exchanger_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in), .x_out(x_out),
  .y_out(y_out), .le_xy(le_xy), .le_yx(le_yx), .path_even(path_even),
  .dir_tx(dir_tx), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
  .x_oe(x_oe), .y_oe(y_oe), .z_oe(z_oe)
);

// File: tb/sim_tri_port_exchanger.sv
`timescale 1ns/1ps
module sim_tri_port_exchanger;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] x_in = '0, y_in = '0, z_in = '0;
  logic [15:0] x_out, y_out, z_out;
  logic [1:0]  x_oe, y_oe, z_oe;
  logic le_xy = 0, le_xz = 0, le_yx = 0, le_zx = 0;
  logic path_even = 0, dir_tx = 0, oe_hi_n = 1, oe_lo_n = 1;
  int checks = 0, errors = 0;
  logic [15:0] m_hold [4];

  always #5 clk = ~clk;

  tri_port_exchanger u0 (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < 4; i++) m_hold[i] <= '0;
    else begin
      if (le_xy) m_hold[0] <= x_in;
      if (le_xz) m_hold[1] <= x_in;
      if (le_yx) m_hold[2] <= y_in;
      if (le_zx) m_hold[3] <= z_in;
    end
  end

  function automatic logic [15:0] lat(input logic en, input logic [15:0] d, input logic [15:0] h);
    return en ? d : h;
  endfunction

  function automatic logic [1:0] oe_of(input logic sel);
    return {sel & ~oe_hi_n, sel & ~oe_lo_n};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R4 y_out", y_out, lat(le_xy, x_in, m_hold[0]));
    chk("R4 z_out", z_out, lat(le_xz, x_in, m_hold[1]));
    chk("R3 x_out", x_out, path_even ? lat(le_yx, y_in, m_hold[2]) : lat(le_zx, z_in, m_hold[3]));
    chk("R5 x_oe", {14'd0, x_oe}, {14'd0, oe_of(~dir_tx)});
    chk("R6 y_oe", {14'd0, y_oe}, {14'd0, oe_of(dir_tx & path_even)});
    chk("R6 z_oe", {14'd0, z_oe}, {14'd0, oe_of(dir_tx & ~path_even)});
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    #2;
    // R10 reset clears held words
    chk("R10 y_out", y_out, 16'h0);
    chk("R10 z_out", z_out, 16'h0);
    chk("R10 x_out", x_out, 16'h0);
    step(); rst_n = 1;

    // R1 transparency, then R2 hold while input changes
    step(); le_xy = 1; x_in = 16'hA5C3; #2;
    chk("R1 transparent", y_out, 16'hA5C3);
    step(); le_xy = 0; x_in = 16'h1234; #2;
    chk("R2 hold", y_out, 16'hA5C3);
    step(); x_in = 16'hFFFF; #2;
    chk("R2 hold again", y_out, 16'hA5C3);
    // R9 control changes leave the held word
    step(); path_even = 1; dir_tx = 1; oe_hi_n = 0; oe_lo_n = 0; #2;
    chk("R9 ctrl change", y_out, 16'hA5C3);
    step(); path_even = 0; dir_tx = 0; oe_hi_n = 1; #2;
    chk("R9 ctrl change 2", y_out, 16'hA5C3);

    // single byte: lower only on Y
    step(); dir_tx = 1; path_even = 1; oe_hi_n = 1; oe_lo_n = 0; #2;
    chk("R6 lower only", {14'd0, y_oe}, 16'h0001);
    chk("R8 z off", {14'd0, z_oe}, 16'h0000);
    chk("R8 x off", {14'd0, x_oe}, 16'h0000);

    // path change while enabled
    step(); oe_hi_n = 0; #2;
    chk("R6 even both", {14'd0, y_oe}, 16'h0003);
    step(); path_even = 0; #2;
    chk("R6 odd both", {14'd0, z_oe}, 16'h0003);
    chk("R8 y off after switch", {14'd0, y_oe}, 16'h0000);

    // read direction, Z source hold
    step(); dir_tx = 0; le_zx = 1; z_in = 16'h0F0F; #2;
    chk("R5 x both", {14'd0, x_oe}, 16'h0003);
    chk("R3 odd read", x_out, 16'h0F0F);
    step(); le_zx = 0; z_in = 16'h7777; path_even = 1; #2;
    chk("R3 even held zero", x_out, 16'h0000);
    step(); path_even = 0; #2;
    chk("R2 z read hold", x_out, 16'h0F0F);

    // all disabled
    step(); oe_hi_n = 1; oe_lo_n = 1; dir_tx = 1; #2;
    chk("R7 all off", {10'd0, x_oe, y_oe, z_oe}, 16'h0000);
    step(); dir_tx = 0; #2;
    chk("R7 all off read", {10'd0, x_oe, y_oe, z_oe}, 16'h0000);

    // random sweep
    for (int n = 0; n < 400; n++) begin
      step();
      x_in = 16'($urandom); y_in = 16'($urandom); z_in = 16'($urandom);
      {le_xy, le_xz, le_yx, le_zx} = 4'($urandom);
      {path_even, dir_tx, oe_hi_n, oe_lo_n} = 4'($urandom);
      #2;
      check_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule